// File: doc/BRIEF.md
# Multiplexed External Bus Strobe Generator

This block sequences accesses on an external memory bus whose 8-bit port can carry both the low address byte and the data. Every access takes a fixed window of four input clocks. In multiplexed operation, the address-latch strobe is high for the first one and a half clocks of the window. During those first two clocks the shared port drives the low address byte, so an external transparent latch can hold it. The port then carries write data, or is released so that read data can come in.

In demultiplexed operation the port carries data for the whole window. The latch strobe then either free-runs with the same shape every four clocks, or is held high by a control input. The operating mode is taken from a select input only while the power-on reset is asserted. A plain reset does not change it.

A requester presents a request with a 24-bit address, write data and access kind. The block accepts the request at the end of a window. It returns read data with a one-clock completion pulse, and drives an active-low program-store enable during external program fetches.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While either reset input is low, `ale_o` is 1, `port_o` is 8'hFF with `port_oe_o` = 1, `psen_no` is 1 and `done_o` is 0.
- R2: The mode is loaded from `demux_i` (0 = multiplexed, 1 = demultiplexed) only on clock edges while `por_ni` is low. Changing `demux_i` and pulsing only `rst_ni` leaves the mode unchanged.
- R3: A free-running phase counts 0,1,2,3 on each rising edge, starting at 0 after reset. `gnt_o` is high exactly during phase 3. `req_i` and its fields are sampled at the rising edge that ends phase 3, and an accepted access occupies the next phases 0 to 3.
- R4: In multiplexed mode, `ale_o` is high from the start of phase 0 until the middle of phase 1 (1.5 clocks) of each active window and low otherwise. Back-to-back accesses give one pulse every 4 clocks. `ale_off_i` has no effect in this mode.
- R5: In multiplexed mode, during phases 0 and 1 of an active window the port drives address bits [7:0]. In phases 2 and 3 it drives the write data for a write, or has `port_oe_o` = 0 for a read.
- R6: In demultiplexed mode with `ale_off_i` = 0, `ale_o` follows the 1.5-high / 2.5-low shape every 4 clocks whether or not an access is active. With `ale_off_i` = 1 it is held high.
- R7: In demultiplexed mode the port drives the write data for all four phases of a write window and is released for all four phases of a read window. With no active window the port drives 8'hFF.
- R8: `psen_no` is 0 in phases 2 and 3 of a fetch window and 1 otherwise. A fetch is always a read, whatever `we_i` says.
- R9: Read data is taken from `port_i` at the rising edge that ends phase 3 of a read or fetch window. It appears on `rdata_o` and stays there. `done_o` is high for the one clock after the end of every access.
- R10: `addr_o` shows the full 24-bit address of the active access for its whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; both edges are used |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ni | input | 1 | Asynchronous active-low power-on reset; mode loads while low |
| demux_i | input | 1 | Mode select: 0 multiplexed, 1 demultiplexed |
| ale_off_i | input | 1 | Holds the strobe high in demultiplexed mode |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write |
| fetch_i | input | 1 | 1 = program fetch (read) |
| addr_i | input | 24 | Access address |
| wdata_i | input | 8 | Write data |
| port_i | input | 8 | Value seen on the shared port |
| gnt_o | output | 1 | Request is taken at the coming rising edge |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Last read data |
| addr_o | output | 24 | Address of the active access |
| ale_o | output | 1 | Address-latch strobe |
| psen_no | output | 1 | Active-low program-store enable |
| port_o | output | 8 | Value driven on the shared port |
| port_oe_o | output | 1 | Port output enable |

## Verification
A behavioural model in the bench predicts every output at both the high and the low half of every clock, so the 1.5-clock strobe width is checked at half-cycle resolution. Writes, reads, fetches (including a fetch that also requests a write) and back-to-back reads are run in multiplexed mode. Comparing these cases shows whether the address and data phases, port direction and program-store timing are right.

`port_i` changes every clock, so a read that captures one edge early or late gets the wrong byte. Running idle windows in demultiplexed mode shows whether the strobe free-runs and whether the strobe-off input holds it high, while the same input in multiplexed mode must change nothing. A reset pulse with the mode select flipped shows whether the mode is kept.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  localparam int unsigned CYCLE_CLKS = 4;
  localparam int unsigned PH_W       = $clog2(CYCLE_CLKS);
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_FIRST    = phase_t'(0);
  localparam phase_t PH_STRB_END = phase_t'(1);  // strobe falls mid-phase
  localparam phase_t PH_DATA     = phase_t'(2);  // first data phase
  localparam phase_t PH_LAST     = phase_t'(CYCLE_CLKS - 1);
endpackage

// File: rtl/ext_bus_phase_gen.sv
module ext_bus_phase_gen
  import ext_bus_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_t phase_o,
  output logic   late_half_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_o <= PH_FIRST;
    else if (phase_o == PH_LAST) phase_o <= PH_FIRST;
    else                        phase_o <= phase_o + phase_t'(1);
  end

  // falling-edge flop marks the second half of the strobe-end phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) late_half_o <= 1'b0;
    else         late_half_o <= (phase_o == PH_STRB_END);
  end
endmodule

// File: rtl/ext_bus_strobe_shape.sv
module ext_bus_strobe_shape
  import ext_bus_pkg::*;
(
  input  logic   rst_ni,
  input  logic   mux_mode_i,
  input  logic   ale_off_i,
  input  logic   active_i,
  input  phase_t phase_i,
  input  logic   late_half_i,
  output logic   ale_o
);
  logic win;

  assign win = (phase_i == PH_FIRST) || ((phase_i == PH_STRB_END) && !late_half_i);

  always_comb begin
    if (!rst_ni)         ale_o = 1'b1;
    else if (mux_mode_i) ale_o = active_i && win;
    else                 ale_o = ale_off_i || win;
  end
endmodule

// File: rtl/ext_bus_port_ctl.sv
module ext_bus_port_ctl
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_t            phase_i,
  input  logic              mux_mode_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] port_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              psen_no,
  output logic [DATA_W-1:0] port_o,
  output logic              port_oe_o
);
  logic              we_q, fetch_q;
  logic [DATA_W-1:0] wdata_q;
  logic              end_edge, addr_phase;

  assign end_edge   = (phase_i == PH_LAST);
  assign addr_phase = mux_mode_i && (phase_i < PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      we_q     <= 1'b0;
      fetch_q  <= 1'b0;
      addr_o   <= '0;
      wdata_q  <= '0;
      rdata_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= active_o && end_edge;
      if (end_edge) begin
        if (active_o && !we_q) rdata_o <= port_i;
        active_o <= req_i;
        if (req_i) begin
          we_q    <= we_i && !fetch_i;
          fetch_q <= fetch_i;
          addr_o  <= addr_i;
          wdata_q <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    port_o    = '1;
    port_oe_o = 1'b1;
    if (active_o) begin
      if (addr_phase)   port_o = addr_o[DATA_W-1:0];
      else if (we_q)    port_o = wdata_q;
      else              port_oe_o = 1'b0;
    end
  end

  assign psen_no = !(active_o && fetch_q && (phase_i >= PH_DATA));
endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              demux_i,
  input  logic              ale_off_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] port_i,
  output logic              gnt_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic [DATA_W-1:0] port_o,
  output logic              port_oe_o
);
  logic   rst_n_all, mux_mode_q, active, late_half;
  phase_t phase;

  assign rst_n_all = rst_ni && por_ni;

  // mode is loaded only while power-on reset is held
  always_ff @(posedge clk_i) begin
    if (!por_ni) mux_mode_q <= !demux_i;
  end

  ext_bus_phase_gen i_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_all),
    .phase_o     (phase),
    .late_half_o (late_half)
  );

  ext_bus_strobe_shape i_strobe (
    .rst_ni      (rst_n_all),
    .mux_mode_i  (mux_mode_q),
    .ale_off_i   (ale_off_i),
    .active_i    (active),
    .phase_i     (phase),
    .late_half_i (late_half),
    .ale_o       (ale_o)
  );

  ext_bus_port_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_all),
    .phase_i    (phase),
    .mux_mode_i (mux_mode_q),
    .req_i      (req_i),
    .we_i       (we_i),
    .fetch_i    (fetch_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .port_i     (port_i),
    .active_o   (active),
    .addr_o     (addr_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o),
    .psen_no    (psen_no),
    .port_o     (port_o),
    .port_oe_o  (port_oe_o)
  );

  assign gnt_o = (phase == PH_LAST);
endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic mux_mode_q,
  input logic ale_o,
  input logic port_oe_o,
  input logic psen_no,
  input logic done_o,
  input logic gnt_o
);
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!por_ni)
    $past(por_ni) |-> $stable(mux_mode_q));

  p_gnt_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    gnt_o |=> !gnt_o);

  p_addr_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (mux_mode_q && ale_o) |-> port_oe_o);

  p_fetch_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !psen_no |-> !port_oe_o);

  p_done_after_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    done_o |-> $past(gnt_o));
endmodule

bind ext_bus_strobe_gen ext_bus_strobe_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ni     (por_ni),
  .mux_mode_q (mux_mode_q),
  .ale_o      (ale_o),
  .port_oe_o  (port_oe_o),
  .psen_no    (psen_no),
  .done_o     (done_o),
  .gnt_o      (gnt_o)
);

// File: tb/test_ext_bus_strobe_gen.sv
module test_ext_bus_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, demux = 1'b0, ale_off = 1'b0;
  logic        req = 1'b0, we = 1'b0, fetch = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0, port_in = '0;
  logic        gnt, done, ale, psen_n, port_oe;
  logic [7:0]  rdata, port_out;
  logic [23:0] addr_out;

  int n_chk = 0, n_err = 0, n_step = 0;
  bit r2_win = 0;

  // reference model state
  int          m_ph = 0;
  bit          m_act = 0, m_we = 0, m_fetch = 0, m_done = 0, m_took = 0, m_mux = 1;
  logic [23:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rd = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  ext_bus_strobe_gen i_ext_bus_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .demux_i(demux), .ale_off_i(ale_off),
    .req_i(req), .we_i(we), .fetch_i(fetch), .addr_i(addr), .wdata_i(wdata), .port_i(port_in),
    .gnt_o(gnt), .done_o(done), .rdata_o(rdata), .addr_o(addr_out), .ale_o(ale),
    .psen_no(psen_n), .port_o(port_out), .port_oe_o(port_oe)
  );

  always @(posedge clk) begin
    m_took = 0;
    if (!por_n) m_mux = !demux;
    if (!rst_n || !por_n) begin
      m_ph = 0; m_act = 0; m_we = 0; m_fetch = 0; m_addr = '0; m_wd = '0; m_rd = '0; m_done = 0;
    end else begin
      m_done = m_act && (m_ph == 3);
      if (m_ph == 3) begin
        if (m_act && !m_we) m_rd = port_in;
        m_act = req;
        if (req) begin
          m_took = 1; m_we = we && !fetch; m_fetch = fetch; m_addr = addr; m_wd = wdata;
        end
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic sample(input bit late);
    bit   in_rst, win, e_ale, e_oe, e_psen;
    logic [7:0] e_port;
    string t_ale, t_port;
    in_rst = !rst_n || !por_n;
    if (in_rst) begin
      chk("R1", "ale", ale, 1); chk("R1", "port_oe", port_oe, 1);
      chk("R1", "port", port_out, 8'hFF); chk("R1", "psen", psen_n, 1); chk("R1", "done", done, 0);
      return;
    end
    win   = (m_ph == 0) || (m_ph == 1 && !late);
    e_ale = m_mux ? (m_act && win) : (ale_off || win);
    t_ale = r2_win ? "R2" : (m_mux ? "R4" : "R6");
    chk(t_ale, late ? "ale late half" : "ale early half", ale, e_ale);
    e_oe = 1; e_port = 8'hFF;
    if (m_act) begin
      if (m_mux && m_ph < 2) e_port = m_addr[7:0];
      else if (m_we)         e_port = m_wd;
      else                   e_oe = 0;
    end
    t_port = m_mux ? "R5" : "R7";
    chk(t_port, "port_oe", port_oe, e_oe);
    if (e_oe) chk(t_port, "port", port_out, e_port);
    e_psen = !(m_act && m_fetch && m_ph >= 2);
    chk("R8", "psen", psen_n, e_psen);
    chk("R3", "gnt", gnt, m_ph == 3);
    chk("R9", "done", done, m_done);
    chk("R9", "rdata", rdata, m_rd);
    if (m_act) chk("R10", "addr", addr_out, m_addr);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1 sample(0);
      #2.5 sample(1);
    end
  end

  task automatic step();
    @(posedge clk); #2;
    n_step++;
    port_in = 8'(n_step * 37 + 5);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic issue(input bit w, input bit f, input logic [23:0] a, input logic [7:0] d);
    int guard;
    req = 1; we = w; fetch = f; addr = a; wdata = d;
    guard = 0;
    step();
    while (!m_took && guard < 16) begin step(); guard++; end
    req = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL R3 watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    // R1: power-on reset, multiplexed mode selected
    idle(3);
    rst_n = 1; por_n = 1;
    idle(6);
    // R4 R5 R10 multiplexed write, read, fetch
    issue(1, 0, 24'h123456, 8'hA5);
    issue(0, 0, 24'hABCDEF, 8'h00);
    issue(1, 1, 24'h00FF3C, 8'h77);   // R8: fetch forces a read
    idle(5);
    // back-to-back reads with ale_off set: no effect in this mode (R4)
    ale_off = 1;
    issue(0, 0, 24'h000001, 8'h00);
    issue(0, 0, 24'h0000FE, 8'h00);
    issue(0, 1, 24'h7F0080, 8'h00);
    idle(6);
    ale_off = 0;
    // R2: plain reset with select flipped keeps multiplexed mode
    demux = 1;
    rst_n = 0; idle(3); rst_n = 1;
    r2_win = 1; idle(8); r2_win = 0;
    issue(0, 0, 24'h5A5A5A, 8'h00);
    idle(5);
    // power-on reset into demultiplexed mode
    por_n = 0; idle(3); por_n = 1;
    idle(9);                            // R6 free-running strobe
    issue(1, 0, 24'h0C0FFE, 8'h3C);     // R7
    issue(0, 0, 24'hFEDCBA, 8'h00);
    issue(0, 1, 24'h100200, 8'h00);
    idle(5);
    ale_off = 1;                        // R6 held high
    idle(6);
    issue(0, 0, 24'h00AA55, 8'h00);
    issue(1, 0, 24'h00AA56, 8'hC3);
    idle(5);
    ale_off = 0;
    idle(6);
    summary();
    $finish;
  end
endmodule